// File: doc/BRIEF.md
# DC Breaker Trip and Reclose Sequencer

This block times the three switches of a mechanical DC breaker: a main interrupter, a residual current switch and a resonant injection switch. Grid protection sends an order on one active-low line. A low level asks the breaker to open. A return to high after a trip asks it to reclose. Every mechanical delay is counted in pulses of a tick-enable input, so the same logic runs at any simulation step.

On a trip, the block waits out the opening delay. It then drops the command for the main and residual switches and, at the same edge, fires the injection switch for a fixed pulse. A switch that has been commanded open still reports closed while the magnitude of its measured current is at or above its chopping threshold. It reports open only once the current falls below that threshold. The injection capacitor must first be precharged: a button sets a latch, the latch stays set for a timed interval, and only then is the breaker armed. A trip that arrives before the breaker is armed still opens the main path, but it does not fire the injection switch and it raises an error flag.

Top module: `dcb_sequencer`

## Requirements
- R1: After reset, the main and residual switches are commanded closed and report closed (1), the injection switch is commanded open and reports open (0), and `chg_on`, `armed` and `err` are 0.
- R2: A high `chg_btn` while neither charging nor armed sets `chg_on` at the next edge. `armed` stays 0 until the T_CHG-th tick counted after that. At that tick's edge `chg_on` falls and `armed` rises, and `armed` then stays set.
- R3: When `order_n` is sampled at 0 in the closed steady state, `main_cmd` and `resid_cmd` fall at the edge of the T_OPEN-th following tick. If the breaker is armed, `inj_cmd` rises at that same edge.
- R4: A switch state output becomes 1 one clock after its command becomes 1 (1 = closed, 0 = open).
- R5: A switch whose command is 0 keeps its state at 1 while the absolute value of its signed current is at least its threshold (THR_MR for main and residual, THR_INJ for injection). It changes to 0 one clock after the magnitude is below the threshold, and it stays 0 while the command remains 0, whatever the current does.
- R6: `inj_cmd` stays 1 for exactly T_INJ ticks and falls at the edge of the T_INJ-th tick. `main_cmd` stays 0 throughout.
- R7: When `order_n` is sampled at 1 in the open steady state, `main_cmd` and `resid_cmd` rise at the edge of the T_CLS-th following tick.
- R8: The level of `order_n` is ignored while the opening delay, the injection pulse or the reclose delay is running. It is sampled again only in the closed or open steady state.
- R9: A trip that completes while `armed` is 0 opens the main and residual commands but leaves `inj_cmd` at 0, and it sets `err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable; one pulse is one delay unit |
| order_n | input | 1 | Protection order: 0 = open, 1 = close |
| chg_btn | input | 1 | Starts the capacitor precharge |
| i_main | input | IW | Signed current through the main interrupter |
| i_resid | input | IW | Signed current through the residual switch |
| i_inj | input | IW | Signed current through the injection switch |
| main_cmd | output | 1 | Main interrupter command (1 = close) |
| resid_cmd | output | 1 | Residual switch command (1 = close) |
| inj_cmd | output | 1 | Injection switch command (1 = close) |
| main_st | output | 1 | Main interrupter state (1 = closed) |
| resid_st | output | 1 | Residual switch state (1 = closed) |
| inj_st | output | 1 | Injection switch state (1 = closed) |
| chg_on | output | 1 | Precharge in progress |
| armed | output | 1 | Capacitor charged; injection available |
| err | output | 1 | A trip completed without a charged capacitor |

## Verification
Command outputs are registered in the sequencer, so they change at the very edge that carries the last counted tick. Switch states change one clock after that. Orders take effect at the first edge that samples them. The bench drives each tick as a single-cycle pulse and reads outputs at the following falling edge. It checks each command both one tick early (unchanged) and on the final tick (changed), and it checks a switch state only after one more clock. Chopping vectors are applied one per clock, and each expected state is read one clock later.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [2:0] {
    SQ_CLOSED = 3'd0,
    SQ_TRIP   = 3'd1,
    SQ_INJ    = 3'd2,
    SQ_OPEN   = 3'd3,
    SQ_RECL   = 3'd4
  } seq_t;
endpackage

// File: rtl/brk_charge.sv
module brk_charge #(
  parameter int T_CHG = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic chg_btn,
  output logic chg_on,
  output logic armed
);
  localparam int CW = $clog2(T_CHG + 1);
  localparam logic [CW-1:0] LAST = CW'(T_CHG - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_on <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
    end else if (!chg_on && !armed && chg_btn) begin
      chg_on <= 1'b1;
      cnt    <= '0;
    end else if (chg_on && tick) begin
      if (cnt == LAST) begin
        chg_on <= 1'b0;
        armed  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  arm_after_charge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(chg_on));

  // R2
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);
endmodule

// File: rtl/brk_switch.sv
module brk_switch #(
  parameter int IW   = 16,
  parameter int THR  = 10,
  parameter bit INIT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd,
  input  logic signed [IW-1:0] cur,
  output logic                 st
);
  localparam logic [IW-1:0] THR_V = IW'(THR);

  logic [IW-1:0] mag;

  always_comb mag = cur[IW-1] ? IW'(-cur) : IW'(cur);

  always_ff @(posedge clk) begin
    if (rst)           st <= INIT;
    else if (cmd)      st <= 1'b1;
    else if (mag < THR_V) st <= 1'b0;
  end

  // R4
  close_follows_chk: assert property (@(posedge clk) disable iff (rst)
    cmd |=> st);

  // R5
  arc_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (st && !cmd && mag >= THR_V) |=> st);
endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
  import brk_pkg::*;
#(
  parameter int T_OPEN = 8,
  parameter int T_INJ  = 30,
  parameter int T_CLS  = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic order_n,
  input  logic armed,
  output logic cmd_mr,
  output logic cmd_inj,
  output logic err
);
  localparam int TMAX = (T_OPEN > T_INJ) ? ((T_OPEN > T_CLS) ? T_OPEN : T_CLS)
                                         : ((T_INJ > T_CLS) ? T_INJ : T_CLS);
  localparam int CW = $clog2(TMAX + 1);

  seq_t          state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          done;

  always_comb begin
    case (state)
      SQ_TRIP: last = CW'(T_OPEN - 1);
      SQ_INJ:  last = CW'(T_INJ - 1);
      default: last = CW'(T_CLS - 1);
    endcase
    done = tick && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_CLOSED;
      cnt     <= '0;
      cmd_mr  <= 1'b1;
      cmd_inj <= 1'b0;
      err     <= 1'b0;
    end else begin
      case (state)
        SQ_CLOSED: if (!order_n) begin
          state <= SQ_TRIP;
          cnt   <= '0;
        end
        SQ_TRIP: if (done) begin
          cmd_mr <= 1'b0;
          cnt    <= '0;
          if (armed) begin
            cmd_inj <= 1'b1;
            state   <= SQ_INJ;
          end else begin
            err   <= 1'b1;
            state <= SQ_OPEN;
          end
        end else if (tick) cnt <= cnt + 1'b1;
        SQ_INJ: if (done) begin
          cmd_inj <= 1'b0;
          cnt     <= '0;
          state   <= SQ_OPEN;
        end else if (tick) cnt <= cnt + 1'b1;
        SQ_OPEN: if (order_n) begin
          state <= SQ_RECL;
          cnt   <= '0;
        end
        SQ_RECL: if (done) begin
          cmd_mr <= 1'b1;
          cnt    <= '0;
          state  <= SQ_CLOSED;
        end else if (tick) cnt <= cnt + 1'b1;
        default: state <= SQ_CLOSED;
      endcase
    end
  end

  // R6
  inj_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_inj |-> !cmd_mr);

  // R9
  inj_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_inj) |-> armed);

  // R8
  hold_no_reclose_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_INJ) |=> !cmd_mr);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(TMAX - 1));
endmodule

// File: rtl/dcb_sequencer.sv
module dcb_sequencer #(
  parameter int IW      = 16,
  parameter int THR_MR  = 10,
  parameter int THR_INJ = 30,
  parameter int T_OPEN  = 8,
  parameter int T_INJ   = 30,
  parameter int T_CLS   = 50,
  parameter int T_CHG   = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 order_n,
  input  logic                 chg_btn,
  input  logic signed [IW-1:0] i_main,
  input  logic signed [IW-1:0] i_resid,
  input  logic signed [IW-1:0] i_inj,
  output logic                 main_cmd,
  output logic                 resid_cmd,
  output logic                 inj_cmd,
  output logic                 main_st,
  output logic                 resid_st,
  output logic                 inj_st,
  output logic                 chg_on,
  output logic                 armed,
  output logic                 err
);
  localparam int NSW = 3;

  logic                 cmd_mr, cmd_inj;
  logic [NSW-1:0]       cmd_v, st_v;
  logic signed [IW-1:0] cur_a [NSW];

  brk_charge #(.T_CHG(T_CHG)) u_chg (
    .clk(clk), .rst(rst), .tick(tick), .chg_btn(chg_btn),
    .chg_on(chg_on), .armed(armed)
  );

  brk_fsm #(.T_OPEN(T_OPEN), .T_INJ(T_INJ), .T_CLS(T_CLS)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .order_n(order_n), .armed(armed),
    .cmd_mr(cmd_mr), .cmd_inj(cmd_inj), .err(err)
  );

  always_comb begin
    cmd_v    = {cmd_inj, cmd_mr, cmd_mr};
    cur_a[0] = i_main;
    cur_a[1] = i_resid;
    cur_a[2] = i_inj;
  end

  for (genvar g = 0; g < NSW; g++) begin : g_sw
    brk_switch #(
      .IW(IW),
      .THR((g == NSW - 1) ? THR_INJ : THR_MR),
      .INIT(g != NSW - 1)
    ) u_sw (
      .clk(clk), .rst(rst), .cmd(cmd_v[g]), .cur(cur_a[g]), .st(st_v[g])
    );
  end

  assign main_cmd  = cmd_mr;
  assign resid_cmd = cmd_mr;
  assign inj_cmd   = cmd_inj;
  assign main_st   = st_v[0];
  assign resid_st  = st_v[1];
  assign inj_st    = st_v[2];
endmodule

// File: tb/sim_dcb_sequencer.sv
module sim_dcb_sequencer;
  localparam int IW = 16, T_OPEN = 4, T_INJ = 6, T_CLS = 5, T_CHG = 7;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, order_n = 1'b1, chg_btn = 1'b0;
  logic signed [IW-1:0] i_main = 16'sd500, i_resid = 16'sd500, i_inj = 16'sd0;
  logic main_cmd, resid_cmd, inj_cmd, main_st, resid_st, inj_st, chg_on, armed, err;
  int n_chk = 0, n_bad = 0;

  localparam int NV = 7;
  localparam logic signed [IW-1:0] VI [NV] = '{16'sd500, -16'sd300, 16'sd10, -16'sd10,
                                               16'sd12, -16'sd9, 16'sd200};
  localparam logic VE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  dcb_sequencer #(.IW(IW), .THR_MR(10), .THR_INJ(30), .T_OPEN(T_OPEN),
                  .T_INJ(T_INJ), .T_CLS(T_CLS), .T_CHG(T_CHG)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .order_n(order_n), .chg_btn(chg_btn),
    .i_main(i_main), .i_resid(i_resid), .i_inj(i_inj),
    .main_cmd(main_cmd), .resid_cmd(resid_cmd), .inj_cmd(inj_cmd),
    .main_st(main_st), .resid_st(resid_st), .inj_st(inj_st),
    .chg_on(chg_on), .armed(armed), .err(err)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 main_cmd", main_cmd, 1);  chk("R1 resid_cmd", resid_cmd, 1);
    chk("R1 main_st", main_st, 1);    chk("R1 resid_st", resid_st, 1);
    chk("R1 inj_cmd", inj_cmd, 0);    chk("R1 inj_st", inj_st, 0);
    chk("R1 armed", armed, 0);        chk("R1 err", err, 0);
    chk("R1 chg_on", chg_on, 0);

    // R9 trip while unarmed
    order_n = 1'b0;
    step(1);
    ticks(T_OPEN - 1);
    chk("R3 main_cmd before delay", main_cmd, 1);
    ticks(1);
    chk("R3 main_cmd opened", main_cmd, 0);
    chk("R3 resid_cmd opened", resid_cmd, 0);
    chk("R9 inj_cmd not fired", inj_cmd, 0);
    chk("R9 err set", err, 1);

    // R5 chopping table on main switch
    for (int v = 0; v < NV; v++) begin
      i_main = VI[v];
      step(1);
      chk($sformatf("R5 main_st vec%0d", v), main_st, VE[v]);
    end
    chk("R5 resid_st held by current", resid_st, 1);
    i_resid = -16'sd5;
    step(1);
    chk("R5 resid_st opens", resid_st, 0);

    // R7 reclose
    order_n = 1'b1;
    step(1);
    ticks(T_CLS - 1);
    chk("R7 main_cmd before delay", main_cmd, 0);
    ticks(1);
    chk("R7 main_cmd reclosed", main_cmd, 1);
    chk("R7 resid_cmd reclosed", resid_cmd, 1);
    step(1);
    chk("R4 main_st closed", main_st, 1);
    chk("R4 resid_st closed", resid_st, 1);
    chk("R9 err sticky", err, 1);

    // R2 precharge
    do_reset();
    chk("R1 err cleared", err, 0);
    i_main = 16'sd500; i_resid = 16'sd500; i_inj = 16'sd200;
    chg_btn = 1'b1;
    step(1);
    chg_btn = 1'b0;
    chk("R2 chg_on set", chg_on, 1);
    ticks(T_CHG - 1);
    chk("R2 armed not yet", armed, 0);
    ticks(1);
    chk("R2 armed", armed, 1);
    chk("R2 chg_on cleared", chg_on, 0);

    // R3/R8 armed trip, order released during delay
    order_n = 1'b0;
    step(1);
    order_n = 1'b1;
    ticks(T_OPEN - 1);
    chk("R8 trip continues", main_cmd, 1);
    chk("R3 inj_cmd before delay", inj_cmd, 0);
    ticks(1);
    chk("R3 main_cmd opened", main_cmd, 0);
    chk("R3 inj_cmd fired", inj_cmd, 1);
    chk("R4 inj_st lags one clock", inj_st, 0);
    step(1);
    chk("R4 inj_st closed", inj_st, 1);

    // R6 injection pulse, R8 reclose ignored during it
    ticks(T_INJ - 1);
    chk("R6 inj_cmd held", inj_cmd, 1);
    chk("R8 no reclose during pulse", main_cmd, 0);
    ticks(1);
    chk("R6 inj_cmd released", inj_cmd, 0);
    chk("R5 inj_st held by current", inj_st, 1);
    i_inj = -16'sd30;
    step(1);
    chk("R5 inj_st at threshold", inj_st, 1);
    i_inj = -16'sd29;
    step(1);
    chk("R5 inj_st opens", inj_st, 0);
    chk("R9 err clear when armed", err, 0);

    // R7 reclose sampled after release
    ticks(T_CLS - 1);
    chk("R7 main_cmd before delay", main_cmd, 0);
    ticks(1);
    chk("R7 main_cmd reclosed", main_cmd, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule